// File: doc/BRIEF.md
# Bit-Serial Clock-Chip Responder with Battery RAM

This block plays the clock-chip end of a three-wire serial link that a host bit-bangs from a control register: an enable line, a serial clock and a single data line. Every transaction is sixteen bit times long. The first eight samples build a command byte. The last eight carry a data byte in, or return a byte out on the data output, most significant bit first.

The block holds a small battery-backed RAM, a status byte and a fixed control byte. It also presents six BCD timekeeping values, which come in on input ports because the block does not count time itself. RAM writes and the status flag-clear operation commit on the sixteenth sample. A flag clear also sends a one-cycle pulse toward the host interrupt logic, which uses it to drop the matching interrupt bit.

All three link inputs pass through a synchronizer of `SYNC_STAGES` flops in the system clock domain. A falling edge of the serial clock is found by comparing each synchronized sample with the one before it.

Top module: `rtc_ser_slave`

## Requirements
- R1: After reset the status byte is 0x90 and RAM byte i holds (i*29 + 7) mod 256. The data output is 0 and the clear pulse is low.
- R2: Bits are taken only on a high-to-low change of the synchronized serial clock while enable is high. Data changes at other times, and clock activity while enable is low, have no effect.
- R3: The first eight samples of a transaction shift into the command byte, most significant bit first.
- R4: During samples 9 to 16 of a read command, the data output shows bit (7 − k) of the selected byte after sample 9+k, so the byte leaves MSB first. The output is updated within SYNC_STAGES+1 system clocks after the serial clock falls.
- R5: Commands 0x00 to 0x1F read RAM byte [command].
- R6: Command 0x30 reads the status byte. Command 0x31 reads the control byte CTRL_INIT (default 0x00).
- R7: Within the window 0x20 to 0x2F, command 0x20 returns seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month and 0x26 year. Every other command in the window returns 0x00.
- R8: On the sixteenth sample, a command from 0x80 to 0x9F writes the received data byte into RAM[command − 0x80]. A transaction cut short before its sixteenth sample changes no RAM byte.
- R9: On the sixteenth sample, command 0xB1 with data bit 2 set clears status bits 4 and 3 and drives the clear output high for exactly one system clock. If data bit 2 is clear, the status is unchanged and no pulse is given.
- R10: While enable is low, the sample count and the command byte return to zero. The next transaction therefore starts its command from the first falling edge after enable rises.
- R11: Falling edges after the sixteenth are ignored until enable drops. They cause no second commit and leave the data output unchanged.
- R12: For write commands and commands that select nothing, the data output holds its previous level for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_i | input | 1 | Link enable from host; low aborts a transaction |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_dat_i | input | 1 | Serial data from host |
| tm_sec_i | input | 8 | BCD seconds |
| tm_min_i | input | 8 | BCD minutes |
| tm_hour_i | input | 8 | BCD hours |
| tm_mday_i | input | 8 | BCD day of month |
| tm_mon_i | input | 8 | BCD month, 1 to 12 |
| tm_year_i | input | 8 | BCD year modulo 100 |
| ser_dat_o | output | 1 | Serial read data toward host |
| irq_clr_o | output | 1 | One-cycle pulse that clears the host interrupt bit |

## Verification
The hardest conditions to reach are the ones the host does wrong: a write cut off after its command, or more than sixteen clock edges in one enable window. In either case the only visible sign is the absence of a change. The bench builds these on purpose. It sends a RAM write with only twelve bits and then reads the target byte back. It sends reads and writes with eight extra trailing bits and checks that the data output and RAM stay put. Between bits it wiggles the data line while the serial clock is low, and it toggles the clock while enable is low. Random RAM traffic then mixes with directed reads of the status, control and time windows.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
   localparam int CMD_W  = 8;
   localparam int DATA_W = 8;
   localparam int PH_END = CMD_W + DATA_W;
   localparam int PH_W   = $clog2(PH_END + 1);
   localparam int IDX_W  = $clog2(DATA_W);

   typedef logic [DATA_W-1:0] byte_t;
   typedef logic [CMD_W-1:0]  cmd_t;

   typedef struct packed {
      byte_t secs;
      byte_t mins;
      byte_t hours;
      byte_t mday;
      byte_t month;
      byte_t year;
   } bcd_time_t;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_RAM,
      SRC_STAT,
      SRC_CTRL,
      SRC_TIME
   } rd_src_e;

   // power-up image of the battery RAM
   function automatic byte_t seed_byte(input int idx);
      return byte_t'(idx * 29 + 7);
   endfunction
endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic sck_i,
   input  logic dat_i,
   output logic en_s,
   output logic dat_s,
   output logic fall_o
);
   localparam int W = 3;

   logic [W*STAGES-1:0] chain_q;
   logic                sck_s;
   logic                sck_d;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {en_i, sck_i, dat_i};
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[W*(STAGES-1)-1:0], en_i, sck_i, dat_i};
         end
      end
   endgenerate

   assign {en_s, sck_s, dat_s} = chain_q[W*STAGES-1 -: W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign fall_o = en_s & sck_d & ~sck_s;
endmodule

// File: rtl/rtc_ser_shift.sv
module rtc_ser_shift
   import rtc_ser_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_s,
   input  logic             fall,
   input  logic             dat_s,
   output logic [PH_W-1:0]  phase_o,
   output cmd_t             cmd_o,
   output logic             data_slot_o,
   output logic             last_slot_o,
   output logic [IDX_W-1:0] bit_idx_o,
   output byte_t            val_full_o
);
   localparam logic [PH_W-1:0]  CMD_V  = PH_W'(CMD_W);
   localparam logic [PH_W-1:0]  END_V  = PH_W'(PH_END);
   localparam logic [PH_W-1:0]  LAST_V = PH_W'(PH_END - 1);
   localparam logic [IDX_W-1:0] TOP_I  = IDX_W'(DATA_W - 1);

   logic [PH_W-1:0]   phase_q;
   cmd_t              cmd_q;
   logic [DATA_W-2:0] val_q;
   logic              take;

   assign take = fall && (phase_q < END_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         cmd_q   <= '0;
         val_q   <= '0;
      end else if (!en_s) begin
         phase_q <= '0;
         cmd_q   <= '0;
         val_q   <= '0;
      end else if (take) begin
         if (phase_q < CMD_V) cmd_q <= {cmd_q[CMD_W-2:0], dat_s};
         else                 val_q <= {val_q[DATA_W-3:0], dat_s};
         phase_q <= phase_q + 1'b1;
      end
   end

   assign phase_o     = phase_q;
   assign cmd_o       = cmd_q;
   assign data_slot_o = take && (phase_q >= CMD_V);
   assign last_slot_o = take && (phase_q == LAST_V);
   assign bit_idx_o   = TOP_I - phase_q[IDX_W-1:0];
   assign val_full_o  = {val_q, dat_s};
endmodule

// File: rtl/rtc_ser_regs.sv
module rtc_ser_regs
   import rtc_ser_pkg::*;
#(
   parameter int    RAM_DEPTH   = 32,
   parameter byte_t STATUS_INIT = 8'h90,
   parameter byte_t CTRL_INIT   = 8'h00,
   parameter byte_t FLAG_MASK   = 8'h18,
   parameter cmd_t  WR_BASE     = 8'h80,
   parameter cmd_t  TIME_BASE   = 8'h20,
   parameter cmd_t  STAT_CMD    = 8'h30,
   parameter cmd_t  CTRL_CMD    = 8'h31,
   parameter cmd_t  CLR_CMD     = 8'hB1,
   parameter int    CLR_BIT     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_t             cmd,
   input  logic             data_slot,
   input  logic             last_slot,
   input  logic [IDX_W-1:0] bit_idx,
   input  byte_t            val_full,
   input  bcd_time_t        tm,
   output logic             dat_o,
   output logic             clr_o,
   output byte_t            status_o
);
   localparam int   AW     = $clog2(RAM_DEPTH);
   localparam cmd_t DEPTH_C = cmd_t'(RAM_DEPTH);
   localparam cmd_t WR_END  = WR_BASE + DEPTH_C;

   byte_t   ram_q [RAM_DEPTH];
   byte_t   status_q;
   rd_src_e src;
   byte_t   time_byte;
   byte_t   sel_byte;
   logic    wr_hit;
   logic    clr_hit;

   always_comb begin
      if (cmd < DEPTH_C)                        src = SRC_RAM;
      else if (cmd[7:4] == TIME_BASE[7:4])      src = SRC_TIME;
      else if (cmd == STAT_CMD)                 src = SRC_STAT;
      else if (cmd == CTRL_CMD)                 src = SRC_CTRL;
      else                                      src = SRC_NONE;
   end

   // index order inside the time window is decoded by host software
   always_comb begin
      unique case (cmd[3:0])
         4'h0:    time_byte = tm.secs;
         4'h1:    time_byte = tm.mins;
         4'h2:    time_byte = tm.hours;
         4'h4:    time_byte = tm.mday;
         4'h5:    time_byte = tm.month;
         4'h6:    time_byte = tm.year;
         default: time_byte = '0;
      endcase
   end

   always_comb begin
      unique case (src)
         SRC_RAM:  sel_byte = ram_q[cmd[AW-1:0]];
         SRC_TIME: sel_byte = time_byte;
         SRC_STAT: sel_byte = status_q;
         SRC_CTRL: sel_byte = CTRL_INIT;
         default:  sel_byte = '0;
      endcase
   end

   assign wr_hit  = last_slot && (cmd >= WR_BASE) && (cmd < WR_END);
   assign clr_hit = last_slot && (cmd == CLR_CMD) && val_full[CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_o <= 1'b0;
      end else if (data_slot && (src != SRC_NONE)) begin
         dat_o <= sel_byte[bit_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= STATUS_INIT;
         clr_o    <= 1'b0;
      end else begin
         clr_o <= clr_hit;
         if (clr_hit) status_q <= status_q & ~FLAG_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= seed_byte(i);
      end else if (wr_hit) begin
         ram_q[cmd[AW-1:0]] <= val_full;
      end
   end

   assign status_o = status_q;
endmodule

// File: rtl/rtc_ser_slave.sv
module rtc_ser_slave
   import rtc_ser_pkg::*;
#(
   parameter int    RAM_DEPTH   = 32,
   parameter int    SYNC_STAGES = 2,
   parameter byte_t STATUS_INIT = 8'h90,
   parameter byte_t CTRL_INIT   = 8'h00,
   parameter byte_t FLAG_MASK   = 8'h18,
   parameter cmd_t  WR_BASE     = 8'h80,
   parameter cmd_t  CLR_CMD     = 8'hB1,
   parameter int    CLR_BIT     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_en_i,
   input  logic       ser_clk_i,
   input  logic       ser_dat_i,
   input  logic [7:0] tm_sec_i,
   input  logic [7:0] tm_min_i,
   input  logic [7:0] tm_hour_i,
   input  logic [7:0] tm_mday_i,
   input  logic [7:0] tm_mon_i,
   input  logic [7:0] tm_year_i,
   output logic       ser_dat_o,
   output logic       irq_clr_o
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (RAM_DEPTH < 2 || RAM_DEPTH > 32 || (RAM_DEPTH & (RAM_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("RAM_DEPTH must be a power of two from 2 to 32");
      end
      if ((int'(WR_BASE) % RAM_DEPTH) != 0 || int'(WR_BASE) < 8'h40) begin : g_bad_base
         $error("WR_BASE must be aligned to RAM_DEPTH and above the read windows");
      end
      if (CLR_BIT < 0 || CLR_BIT >= DATA_W) begin : g_bad_bit
         $error("CLR_BIT outside the data byte");
      end
      if ((CMD_W % DATA_W) != 0) begin : g_bad_width
         $error("CMD_W must be a multiple of DATA_W");
      end
   endgenerate

   logic             en_s;
   logic             dat_s;
   logic             fall;
   logic [PH_W-1:0]  phase;
   cmd_t             cmd;
   logic             data_slot;
   logic             last_slot;
   logic [IDX_W-1:0] bit_idx;
   byte_t            val_full;
   byte_t            status_w;
   bcd_time_t        tm;

   assign tm = '{secs: tm_sec_i, mins: tm_min_i, hours: tm_hour_i,
                 mday: tm_mday_i, month: tm_mon_i, year: tm_year_i};

   rtc_ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (ser_en_i),
      .sck_i  (ser_clk_i),
      .dat_i  (ser_dat_i),
      .en_s   (en_s),
      .dat_s  (dat_s),
      .fall_o (fall)
   );

   rtc_ser_shift u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_s        (en_s),
      .fall        (fall),
      .dat_s       (dat_s),
      .phase_o     (phase),
      .cmd_o       (cmd),
      .data_slot_o (data_slot),
      .last_slot_o (last_slot),
      .bit_idx_o   (bit_idx),
      .val_full_o  (val_full)
   );

   rtc_ser_regs #(
      .RAM_DEPTH   (RAM_DEPTH),
      .STATUS_INIT (STATUS_INIT),
      .CTRL_INIT   (CTRL_INIT),
      .FLAG_MASK   (FLAG_MASK),
      .WR_BASE     (WR_BASE),
      .CLR_CMD     (CLR_CMD),
      .CLR_BIT     (CLR_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .data_slot (data_slot),
      .last_slot (last_slot),
      .bit_idx   (bit_idx),
      .val_full  (val_full),
      .tm        (tm),
      .dat_o     (ser_dat_o),
      .clr_o     (irq_clr_o),
      .status_o  (status_w)
   );
endmodule

// File: rtl/rtc_ser_chk.sv
module rtc_ser_chk #(
   parameter int PH_W   = 5,
   parameter int PH_END = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_clr,
   input logic            dat_o,
   input logic [PH_W-1:0] phase,
   input logic            fall,
   input logic            en_s,
   input logic [7:0]      status
);
   localparam logic [PH_W-1:0] END_V = PH_W'(PH_END);

   assert_clr_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !irq_clr);

   assert_clr_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |-> (phase == END_V));

   assert_status_only_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status)) == 8'h00));

   assert_phase_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= END_V);

   assert_phase_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase) |-> ($past(fall) || !$past(en_s)));

   assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> (phase == '0));

   assert_dout_on_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dat_o) |-> $past(fall));
endmodule

bind rtc_ser_slave rtc_ser_chk #(
   .PH_W   (rtc_ser_pkg::PH_W),
   .PH_END (rtc_ser_pkg::PH_END)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_clr (irq_clr_o),
   .dat_o   (ser_dat_o),
   .phase   (phase),
   .fall    (fall),
   .en_s    (en_s),
   .status  (status_w)
);

// File: tb/sim_rtc_ser_slave.sv
`timescale 1ns/1ps
module sim_rtc_ser_slave;
   localparam int HALF = 5;
   localparam logic [7:0] CTRL_EXP = 8'h00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
   logic [7:0] t_sec, t_min, t_hour, t_mday, t_mon, t_year;
   logic ser_dat_o, irq_clr_o;

   int errors = 0;
   int checks = 0;
   int pulse_cyc = 0;
   logic [7:0] ram_m [32];
   logic [7:0] stat_m;

   always #2 clk = ~clk;

   rtc_ser_slave u0 (
      .clk(clk), .rst_n(rst_n),
      .ser_en_i(ser_en), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .tm_sec_i(t_sec), .tm_min_i(t_min), .tm_hour_i(t_hour),
      .tm_mday_i(t_mday), .tm_mon_i(t_mon), .tm_year_i(t_year),
      .ser_dat_o(ser_dat_o), .irq_clr_o(irq_clr_o)
   );

   always @(negedge clk) if (irq_clr_o) pulse_cyc++;

   function automatic logic [7:0] to_bcd(input int n);
      return 8'(((n / 10) << 4) + (n % 10));
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] c);
      if (c < 8'h20) return ram_m[c[4:0]];
      if (c == 8'h30) return stat_m;
      if (c == 8'h31) return CTRL_EXP;
      case (c)
         8'h20: return t_sec;
         8'h21: return t_min;
         8'h22: return t_hour;
         8'h24: return t_mday;
         8'h25: return t_mon;
         8'h26: return t_year;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_time();
      t_sec  = to_bcd($urandom_range(59));
      t_min  = to_bcd($urandom_range(59));
      t_hour = to_bcd($urandom_range(23));
      t_mday = to_bcd($urandom_range(31, 1));
      t_mon  = to_bcd($urandom_range(12, 1));
      t_year = to_bcd($urandom_range(99));
   endtask

   task automatic send_bit(input logic b, input bit noisy);
      @(negedge clk);
      ser_clk = 1'b1;
      ser_dat = b;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (noisy) begin
         ser_dat = ~b;
         repeat (2) @(negedge clk);
         ser_dat = b;
         @(negedge clk);
      end
   endtask

   // nbits < 16 aborts; nbits > 16 adds trailing edges
   task automatic xfer(input logic [7:0] c, input logic [7:0] v, input int nbits,
                       input bit noisy, output logic [7:0] rd,
                       output bit held, output bit tail_held);
      logic start_lvl, lvl16;
      rd = 8'h00; held = 1'b1; tail_held = 1'b1; lvl16 = 1'b0;
      @(negedge clk);
      start_lvl = ser_dat_o;
      ser_en = 1'b1;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         logic b;
         if (i < 8)       b = c[7 - i];
         else if (i < 16) b = v[15 - i];
         else             b = 1'($urandom);
         send_bit(b, noisy);
         if (i >= 8 && i < 16) rd = {rd[6:0], ser_dat_o};
         if (ser_dat_o !== start_lvl) held = 1'b0;
         if (i == 15) lvl16 = ser_dat_o;
         if (i > 15 && ser_dat_o !== lvl16) tail_held = 1'b0;
      end
      ser_en = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] c);
      logic [7:0] rd; bit h, th;
      xfer(c, 8'h00, 16, 1'b0, rd, h, th);
      chk(req, rd, exp_read(c));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] rd, a, v;
      bit h, th;
      int p0;
      void'($urandom(32'd4711));
      for (int i = 0; i < 32; i++) ram_m[i] = 8'(i * 29 + 7);
      stat_m = 8'h90;
      set_time();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 dout at reset", ser_dat_o, 1'b0);
      chk("R1 no clear pulse", pulse_cyc, 0);
      rd_chk("R1 R5 ram[0] seed", 8'h00);
      rd_chk("R1 R5 ram[31] seed", 8'h1F);
      rd_chk("R1 R6 status 0x90", 8'h30);
      rd_chk("R6 control byte", 8'h31);

      // R7 time window, directed
      for (int c = 8'h20; c <= 8'h2F; c++) rd_chk("R7 time window", 8'(c));
      set_time();
      rd_chk("R7 seconds after change", 8'h20);
      rd_chk("R7 year after change", 8'h26);

      // R3 R4 R5 R8 random traffic
      for (int n = 0; n < 24; n++) begin
         a = 8'($urandom_range(31));
         v = 8'($urandom);
         xfer(8'h80 | a, v, 16, 1'b0, rd, h, th);
         ram_m[a[4:0]] = v;
         chk("R12 write holds dout", h, 1'b1);
         a = 8'($urandom_range(31));
         rd_chk("R3 R4 R5 R8 random ram read", a);
      end

      // R2 noise on data while serial clock low, clock toggles while disabled
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); ser_clk = ~ser_clk; ser_dat = ~ser_dat;
         repeat (HALF) @(negedge clk);
      end
      ser_clk = 1'b0; repeat (HALF) @(negedge clk);
      xfer(8'h09, 8'h00, 16, 1'b1, rd, h, th);
      chk("R2 noisy read ram[9]", rd, ram_m[9]);
      xfer(8'h8A, 8'h3C, 16, 1'b1, rd, h, th);
      ram_m[10] = 8'h3C;
      rd_chk("R2 noisy write ram[10]", 8'h0A);

      // R8 R10 aborted write, then clean start
      xfer(8'h85, ~ram_m[5], 12, 1'b0, rd, h, th);
      rd_chk("R8 R10 aborted write leaves ram[5]", 8'h05);
      xfer(8'hFF, 8'h00, 4, 1'b0, rd, h, th);
      rd_chk("R10 aborted command cleared", 8'h02);

      // R11 trailing edges
      xfer(8'h03, 8'h00, 24, 1'b0, rd, h, th);
      chk("R11 read with tail", rd, ram_m[3]);
      chk("R11 dout held on tail", th, 1'b1);
      xfer(8'h84, 8'hA5, 24, 1'b0, rd, h, th);
      ram_m[4] = 8'hA5;
      rd_chk("R11 no second commit", 8'h04);

      // R12 unknown command keeps level
      xfer(8'h3F, 8'h00, 16, 1'b0, rd, h, th);
      chk("R12 unknown command holds dout", h, 1'b1);
      xfer(8'h40, 8'hFF, 16, 1'b0, rd, h, th);
      chk("R12 command 0x40 holds dout", h, 1'b1);

      // R9 flag clear
      p0 = pulse_cyc;
      xfer(8'hB1, 8'hFB, 16, 1'b0, rd, h, th);
      chk("R9 no pulse without bit 2", pulse_cyc - p0, 0);
      rd_chk("R9 status kept", 8'h30);
      p0 = pulse_cyc;
      xfer(8'hB1, 8'h04, 16, 1'b0, rd, h, th);
      stat_m = stat_m & ~8'h18;
      chk("R9 one-cycle pulse", pulse_cyc - p0, 1);
      rd_chk("R9 status cleared to 0x80", 8'h30);
      chk("R9 status value", stat_m, 8'h80);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule